// File: doc/BRIEF.md
# Execute Unit with Three-Way Compare Flags

This block is the arithmetic and logic stage of a 32-bit processor core. Each cycle it receives a 6-bit operation code, two register operands, a 5-bit shift count and a 16-bit literal. From these it forms a 32-bit result combinationally, in the same cycle. The register file, memory access and branch resolution sit outside it. A branch unit later reads the three status flags to decide conditional jumps.

The block covers these operations:
- Two-operand add and subtract.
- Seven bitwise functions, including the inverted forms NAND, NOR and XNOR.
- Increment and decrement.
- Left and right shifts by the instruction's shift field.
- Add and subtract with a sign-extended literal.
- Literal insertion into the low or high half of a register. For this operation the current register value arrives on the first operand so that the other half is kept.

A compare operation writes nothing to a destination. It loads a small registered status word that holds equal, greater-than and less-than. A nonzero shift field on any operation other than a shift is flagged as an illegal instruction, and that instruction has no effect.

Top module: `alu_exec`

## Requirements
- R1: While `rst_n` is low, all three flags (`flag_eq`, `flag_gt`, `flag_lt`) are 0.
- R2: Operation 0x19 gives `op_a + op_b` and 0x1A gives `op_a - op_b`, both modulo 2^32.
- R3: The bitwise operations are: 0x1B AND, 0x1C OR, 0x1E XOR, 0x1F NAND, 0x20 NOR and 0x21 XNOR, each applied to `op_a` and `op_b`. Operation 0x1D gives `~op_a`.
- R4: Operation 0x15 gives `op_a + 1` and 0x16 gives `op_a - 1`, both wrapping modulo 2^32.
- R5: Operation 0x17 shifts `op_a` left by `shamt`. Operation 0x18 shifts `op_a` right logically by `shamt`. In both cases vacated bits are zero, and a count of 0 returns `op_a` unchanged.
- R6: Operation 0x25 gives `op_a` plus `imm` sign-extended to 32 bits. Operation 0x26 gives `op_a` minus that value. Both are modulo 2^32.
- R7: Operation 0x0B gives `{op_a[31:16], imm}`, and operation 0x0C gives `{imm, op_a[15:0]}`.
- R8: Operation 0x14 drives `result` to 0. After the next rising clock edge, exactly one flag is set, based on a signed comparison of `op_a` with `op_b`: `flag_eq` if they are equal, `flag_gt` if `op_a` is greater, `flag_lt` if `op_a` is less.
- R9: On any cycle whose operation is not a legal 0x14, the flags keep their previous values.
- R10: If `shamt` is nonzero on any operation other than 0x17 and 0x18, then `illegal` is 1 and `result` is 0 in that cycle, and the flags do not change even for 0x14. In every other case `illegal` is 0.
- R11: Operation codes outside those listed in R2 to R8, such as 0x00 and 0x3F, give `result` 0 and `illegal` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status flags |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| opcode | input | 6 | Operation code |
| op_a | input | 32 | First operand; current destination value for half inserts |
| op_b | input | 32 | Second operand |
| shamt | input | 5 | Shift count field of the instruction |
| imm | input | 16 | Literal field of the instruction |
| result | output | 32 | Combinational result |
| illegal | output | 1 | Illegal instruction indication |
| flag_eq | output | 1 | Last compare found the operands equal |
| flag_gt | output | 1 | Last compare found op_a greater (signed) |
| flag_lt | output | 1 | Last compare found op_a less (signed) |

## Verification
The operand pairs are chosen so that different operations give different answers:
- Overlapping bit patterns make each bitwise function distinct from its inverse.
- All-ones and zero values expose wrong carries in add, subtract, increment and decrement.
- Literals with the top bit set separate sign extension from zero extension.
- Shift counts of 0, 4 and 31 on a value with the top bit set show whether a right shift is logical and whether a zero count changes the value.

The compare is driven with pairs whose signed and unsigned orders disagree (-1 against 1, and 0x7FFFFFFF against 0x80000000), which catches an unsigned compare. Compares are followed by other operations and by an illegal compare to show that the flags hold.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_LOLIT = 6'h0B;
   localparam logic [OPC_W-1:0] OPC_HILIT = 6'h0C;
   localparam logic [OPC_W-1:0] OPC_CMP   = 6'h14;
   localparam logic [OPC_W-1:0] OPC_INC   = 6'h15;
   localparam logic [OPC_W-1:0] OPC_DEC   = 6'h16;
   localparam logic [OPC_W-1:0] OPC_SHL   = 6'h17;
   localparam logic [OPC_W-1:0] OPC_SHR   = 6'h18;
   localparam logic [OPC_W-1:0] OPC_ADD   = 6'h19;
   localparam logic [OPC_W-1:0] OPC_SUB   = 6'h1A;
   localparam logic [OPC_W-1:0] OPC_AND   = 6'h1B;
   localparam logic [OPC_W-1:0] OPC_OR    = 6'h1C;
   localparam logic [OPC_W-1:0] OPC_NOT   = 6'h1D;
   localparam logic [OPC_W-1:0] OPC_XOR   = 6'h1E;
   localparam logic [OPC_W-1:0] OPC_NAND  = 6'h1F;
   localparam logic [OPC_W-1:0] OPC_NOR   = 6'h20;
   localparam logic [OPC_W-1:0] OPC_XNOR  = 6'h21;
   localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h25;
   localparam logic [OPC_W-1:0] OPC_SUBI  = 6'h26;

   typedef struct packed {
      logic eq;
      logic gt;
      logic lt;
   } cmp_flags_t;

   function automatic logic opc_is_shift(input logic [OPC_W-1:0] op);
      return (op == OPC_SHL) || (op == OPC_SHR);
   endfunction
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [OPC_W-1:0]  op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y,
   output logic              hit
);
   always_comb begin
      hit = 1'b1;
      unique case (op)
         OPC_AND:  y = a & b;
         OPC_OR:   y = a | b;
         OPC_XOR:  y = a ^ b;
         OPC_NAND: y = ~(a & b);
         OPC_NOR:  y = ~(a | b);
         OPC_XNOR: y = ~(a ^ b);
         OPC_NOT:  y = ~a;
         default: begin
            y   = '0;
            hit = 1'b0;
         end
      endcase
   end

   // R3: inverted forms must complement their base form
   always_comb begin
      if (op == OPC_NAND) a_r3_nand_inv: assert ((y ^ (a & b)) == '1);
   end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
   import alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [OPC_W-1:0]  op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] y,
   output logic              hit
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_sx;
   logic [DATA_W-1:0] addend;
   logic              do_sub;
   logic [DATA_W-1:0] sum;

   assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};

   // one shared adder serves every add/subtract flavour
   always_comb begin
      addend = b;
      do_sub = 1'b0;
      unique case (op)
         OPC_SUB:  do_sub = 1'b1;
         OPC_INC:  addend = DATA_W'(1);
         OPC_DEC: begin addend = DATA_W'(1); do_sub = 1'b1; end
         OPC_ADDI: addend = imm_sx;
         OPC_SUBI: begin addend = imm_sx; do_sub = 1'b1; end
         default:  addend = b;
      endcase
   end

   assign sum = a + (do_sub ? ~addend : addend) + DATA_W'(do_sub);

   always_comb begin
      hit = 1'b1;
      unique case (op)
         OPC_ADD, OPC_SUB, OPC_INC, OPC_DEC, OPC_ADDI, OPC_SUBI: y = sum;
         OPC_LOLIT: y = {a[DATA_W-1:IMM_W], imm};
         OPC_HILIT: y = {imm, a[EXT_W-1:0]};
         default: begin
            y   = '0;
            hit = 1'b0;
         end
      endcase
   end

   // R4: increment of all-ones must wrap to zero
   always_comb begin
      if (op == OPC_INC && a == '1) a_r4_inc_wrap: assert (y == '0);
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int  DATA_W     = 32,
   parameter int  SH_W       = 5,
   parameter bit  USE_STAGES = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [SH_W-1:0]   amt,
   input  logic              go_right,
   output logic [DATA_W-1:0] y
);
   generate
      if (USE_STAGES) begin : g_staged
         logic [DATA_W-1:0] stage [0:SH_W];
         assign stage[0] = a;
         for (genvar s = 0; s < SH_W; s++) begin : g_step
            localparam int DIST = 1 << s;
            assign stage[s+1] = !amt[s] ? stage[s] :
                                go_right ? (stage[s] >> DIST) : (stage[s] << DIST);
         end
         assign y = stage[SH_W];
      end else begin : g_direct
         assign y = go_right ? (a >> amt) : (a << amt);
      end
   endgenerate

   // R5: a zero count passes the operand through
   always_comb begin
      if (amt == '0) a_r5_zero_count: assert (y == a);
   end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output cmp_flags_t        flags
);
   cmp_flags_t next_flags;

   always_comb begin
      next_flags.eq = (a == b);
      next_flags.gt = ($signed(a) > $signed(b));
      next_flags.lt = ($signed(a) < $signed(b));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     flags <= '0;
      else if (load)  flags <= next_flags;
   end

   a_r8_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> $countones(flags) == 1);
   a_r8_equal_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (load && a == b) |=> flags.eq);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(flags));
endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter int SH_W       = 5,
   parameter bit USE_STAGES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [5:0]        opcode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [SH_W-1:0]   shamt,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] result,
   output logic              illegal,
   output logic              flag_eq,
   output logic              flag_gt,
   output logic              flag_lt
);
   initial begin
      if (DATA_W != 2 * IMM_W)
         $error("alu_exec: DATA_W must be twice IMM_W");
      if ((1 << SH_W) != DATA_W)
         $error("alu_exec: SH_W must address every bit of DATA_W");
   end

   logic [DATA_W-1:0] logic_y, arith_y, shift_y;
   logic              logic_hit, arith_hit;
   logic              is_shift, cmp_load;
   cmp_flags_t        flags;

   assign is_shift = opc_is_shift(opcode);
   assign illegal  = (shamt != '0) && !is_shift;
   assign cmp_load = (opcode == OPC_CMP) && !illegal;

   alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op(opcode), .a(op_a), .b(op_b), .y(logic_y), .hit(logic_hit)
   );

   alu_arith_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_arith (
      .op(opcode), .a(op_a), .b(op_b), .imm(imm), .y(arith_y), .hit(arith_hit)
   );

   alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W), .USE_STAGES(USE_STAGES)) u_shift (
      .a(op_a), .amt(shamt), .go_right(opcode == OPC_SHR), .y(shift_y)
   );

   alu_status_reg #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .load(cmp_load), .a(op_a), .b(op_b), .flags(flags)
   );

   always_comb begin
      if (illegal)        result = '0;
      else if (is_shift)  result = shift_y;
      else if (arith_hit) result = arith_y;
      else if (logic_hit) result = logic_y;
      else                result = '0;
   end

   assign flag_eq = flags.eq;
   assign flag_gt = flags.gt;
   assign flag_lt = flags.lt;

   a_r10_no_flag_change: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> $stable({flag_eq, flag_gt, flag_lt}));
   a_r10_quiet_result: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> result == '0);
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> {flag_eq, flag_gt, flag_lt} == 3'b000);
endmodule

// File: tb/alu_exec_test.sv
module alu_exec_test;
   localparam int PERIOD = 10;

   typedef struct {
      logic [31:0] res;
      logic        ill;
      logic [2:0]  flg;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  opcode = '0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [4:0]  shamt = '0;
   logic [15:0] imm = '0;
   logic [31:0] result;
   logic        illegal, flag_eq, flag_gt, flag_lt;

   item_t       sb[$];
   logic [2:0]  model_flags = 3'b000;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   alu_exec uut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
      .shamt(shamt), .imm(imm), .result(result), .illegal(illegal),
      .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_lt(flag_lt)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // expected outcome computed from the requirement text
   task automatic drive(input string tag, input logic [5:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] sh, input logic [15:0] im);
      item_t it;
      logic [31:0] sx;
      sx = {{16{im[15]}}, im};
      it.ill = (sh != 0) && (op != 6'h17) && (op != 6'h18);
      case (op)
         6'h19: it.res = a + b;
         6'h1A: it.res = a - b;
         6'h1B: it.res = a & b;
         6'h1C: it.res = a | b;
         6'h1D: it.res = ~a;
         6'h1E: it.res = a ^ b;
         6'h1F: it.res = ~(a & b);
         6'h20: it.res = ~(a | b);
         6'h21: it.res = ~(a ^ b);
         6'h15: it.res = a + 1;
         6'h16: it.res = a - 1;
         6'h17: it.res = a << sh;
         6'h18: it.res = a >> sh;
         6'h25: it.res = a + sx;
         6'h26: it.res = a - sx;
         6'h0B: it.res = {a[31:16], im};
         6'h0C: it.res = {im, a[15:0]};
         default: it.res = 32'h0;
      endcase
      if (it.ill) it.res = 32'h0;
      if (op == 6'h14 && !it.ill) begin
         if ($signed(a) == $signed(b))     model_flags = 3'b100;
         else if ($signed(a) > $signed(b)) model_flags = 3'b010;
         else                              model_flags = 3'b001;
      end
      it.flg = model_flags;
      it.tag = tag;
      @(negedge clk);
      opcode = op; op_a = a; op_b = b; shamt = sh; imm = im;
      sb.push_back(it);
   endtask

   // monitor: result is stable at the edge, flags are read just after it
   initial begin
      forever begin
         @(posedge clk);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " result"}, result, it.res);
            check({it.tag, " illegal"}, {31'h0, illegal}, {31'h0, it.ill});
            #1;
            check({it.tag, " flags"}, {29'h0, flag_eq, flag_gt, flag_lt}, {29'h0, it.flg});
         end
      end
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset flags", {29'h0, flag_eq, flag_gt, flag_lt}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      drive("R2 add wrap",  6'h19, 32'hFFFF_FFFF, 32'h1, 0, 0);
      drive("R2 add",       6'h19, 32'h1234_5678, 32'h1111_1111, 0, 0);
      drive("R2 sub borrow",6'h1A, 32'h0, 32'h1, 0, 0);
      drive("R3 and",  6'h1B, 32'hF0F0_1234, 32'h0FF0_5678, 0, 0);
      drive("R3 or",   6'h1C, 32'hF0F0_1234, 32'h0FF0_5678, 0, 0);
      drive("R3 not",  6'h1D, 32'hF0F0_1234, 32'h0FF0_5678, 0, 0);
      drive("R3 xor",  6'h1E, 32'hF0F0_1234, 32'h0FF0_5678, 0, 0);
      drive("R3 nand", 6'h1F, 32'hF0F0_1234, 32'h0FF0_5678, 0, 0);
      drive("R3 nor",  6'h20, 32'hF0F0_1234, 32'h0FF0_5678, 0, 0);
      drive("R3 xnor", 6'h21, 32'hF0F0_1234, 32'h0FF0_5678, 0, 0);
      drive("R4 inc wrap", 6'h15, 32'hFFFF_FFFF, 0, 0, 0);
      drive("R4 dec wrap", 6'h16, 32'h0, 0, 0, 0);
      drive("R5 shl 31",   6'h17, 32'h0000_0003, 0, 31, 0);
      drive("R5 shr 31",   6'h18, 32'h8000_0000, 0, 31, 0);
      drive("R5 shr 4",    6'h18, 32'h8765_4321, 0, 4, 0);
      drive("R5 shl 0",    6'h17, 32'h8765_4321, 0, 0, 0);
      drive("R6 addi neg", 6'h25, 32'h5, 0, 0, 16'hFFFF);
      drive("R6 subi neg", 6'h26, 32'h5, 0, 0, 16'h8000);
      drive("R6 addi pos", 6'h25, 32'h10, 0, 0, 16'h7FFF);
      drive("R7 low lit",  6'h0B, 32'hAAAA_BBBB, 0, 0, 16'h1234);
      drive("R7 high lit", 6'h0C, 32'hAAAA_BBBB, 0, 0, 16'h8765);
      drive("R8 cmp lt signed", 6'h14, 32'hFFFF_FFFF, 32'h1, 0, 0);
      drive("R9 hold after add", 6'h19, 32'h3, 32'h4, 0, 0);
      drive("R8 cmp eq",  6'h14, 32'h7, 32'h7, 0, 0);
      drive("R8 cmp gt signed", 6'h14, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0);
      drive("R9 hold on shift", 6'h17, 32'h1, 32'h1, 2, 0);
      drive("R10 illegal add", 6'h19, 32'h3, 32'h4, 3, 0);
      drive("R10 illegal cmp", 6'h14, 32'h1, 32'h9, 1, 0);
      drive("R10 illegal lli", 6'h0B, 32'h1, 32'h9, 16, 16'h5555);
      drive("R8 cmp gt", 6'h14, 32'h1, 32'hFFFF_FFFF, 0, 0);
      drive("R11 nop", 6'h00, 32'h1234, 32'h5678, 0, 0);
      drive("R11 unused code", 6'h3F, 32'h1234, 32'h5678, 0, 0);
      drive("R9 hold end", 6'h1B, 32'hFFFF, 32'hFF, 0, 0);

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule